// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches up to forty asynchronous input lines, split over two register banks of 32 and 8 lines. Every line passes through a synchronizer, and its rising and falling transitions are detected. A line whose chosen transition occurs, and whose interrupt enable is set, latches a sticky pending flag. In the same clock cycle that the flag is latched, the line's own output gives a one-cycle pulse. Software can also fire a line by writing its software-trigger bit. It acknowledges a line by writing 1 to the pending bit, and that write also clears the software-trigger bit.

Some lines in each bank are fixed direct lines, and their trigger cannot be configured. On these lines the trigger-select, software-trigger and pending bits stay at zero and ignore writes. Their interrupt-enable bits start at 1. A combined interrupt output is the OR, over all lines, of each pending flag gated by its enable bit. Registers are reached through a plain 32-bit word bus. A write commits on the clock edge, and a read returns data combinationally.

Top module: `xint_ctrl`

## Requirements
- R1: After reset, the interrupt-enable registers hold the fixed-line patterns (0xFF820000 in bank A, 0x87 in bank B). Every other register reads 0, and `line_pulse` and `irq_any` are low.
- R2: Bank B implements 8 lines. Its register bits 31..8 read as 0, and writes to them have no effect.
- R3: Writes to the enable (0x00/0x20) and event-enable (0x04/0x24) registers change every implemented bit. Writes to rise-select (0x08/0x28), fall-select (0x0C/0x2C), software-trigger (0x10/0x30) and pending (0x14/0x34) change only the non-fixed bits. A fixed line never pulses.
- R4: A line whose enable bit is 0 never sets its pending bit from an input transition, and it does not pulse.
- R5: A rising input with rise-select set, or a falling input with fall-select set, sets the pending bit. It also raises bit i of `line_pulse` (line i, bank B at bits 39..32) for exactly one cycle, starting on the third rising clock edge after the input changes. A transition of the unselected polarity does nothing.
- R6: A software-trigger write fires line i only when all of these hold: the written bit is 1, the stored bit is 0, the line is enabled, and the line is not pending. Firing sets the pending bit and pulses the line in the cycle after the write edge. The register always stores the masked written value.
- R7: Writing 1 to a pending bit clears it and also clears the matching software-trigger bit. Writing 0 has no effect.
- R8: An access whose low two address bits are non-zero, or whose offset is not one of the twelve registers, returns 0 on a read and has no effect on a write.
- R9: `irq_any` is high exactly when some line has both its pending bit and its enable bit set.
- R10: If an input transition would set a pending bit in the same cycle that a clear of that bit commits, the bit stays set and the line pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 40 | Asynchronous external lines (bank A 31..0, bank B 39..32) |
| wr_en | input | 1 | Write strobe, commits on the rising edge |
| addr | input | 10 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| line_pulse | output | 40 | One-cycle pulse for each line when it becomes pending |
| irq_any | output | 1 | OR of all enabled pending flags |

## Verification
A stuck or misdecoded configuration bit shows up in two ways. A line whose transition should produce a pulse stays silent, or a line that should stay silent pulses. Either one appears on `line_pulse` three edges after the input moves, or one cycle after a software write. A wrong pending or software-trigger state stays hidden until a read, a later software write or the combined output exposes it. For that reason the sweep reads back both banks after every line's stimulus, and it rechecks `irq_any` across changes to the enable bits. The per-line sweep covers every line in both polarities, so a fault confined to a single bit position still reaches a check.

// File: rtl/xint_pkg.sv
package xint_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned NUM_BANKS = 2;

   typedef enum logic [2:0] {
      RG_ENABLE  = 3'd0,
      RG_EVENT   = 3'd1,
      RG_RISE    = 3'd2,
      RG_FALL    = 3'd3,
      RG_SWTRIG  = 3'd4,
      RG_PENDING = 3'd5
   } reg_sel_e;

   localparam logic [2:0] LAST_REG = 3'd5;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
   parameter int unsigned N      = 40,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] chain [STAGES];
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
         prev <= '0;
      end else begin
         chain[0] <= din;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         prev <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/xint_decode.sv
module xint_decode
   import xint_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              bank,
   output reg_sel_e          sel
);
   logic aligned, in_window, known;

   always_comb begin
      aligned   = (addr[1:0] == 2'b00);
      in_window = (addr[ADDR_W-1:6] == '0);
      known     = (addr[4:2] <= LAST_REG);
      hit       = aligned && in_window && known;
      bank      = addr[5];
      sel       = reg_sel_e'(addr[4:2]);
   end
endmodule

// File: rtl/xint_bank.sv
module xint_bank
   import xint_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter logic [31:0] FIXED = 32'h0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        rise,
   input  logic [W-1:0]        fall,
   input  logic                wr_en,
   input  reg_sel_e            wr_sel,
   input  logic [W-1:0]        wr_data,
   input  reg_sel_e            rd_sel,
   output logic [WORD_W-1:0]   rd_data,
   output logic [W-1:0]        pulse,
   output logic                irq_req
);
   localparam logic [W-1:0] FIX = FIXED[W-1:0];
   localparam logic [W-1:0] CFG = ~FIX;

   logic [W-1:0] enable_q, event_q, rise_q, fall_q, swtrig_q, pend_q;
   logic [W-1:0] hw_hit, sw_hit, sw_val, clr, pend_d, swtrig_d;
   logic         sw_wr, pd_wr;

   always_comb begin
      sw_wr    = wr_en && (wr_sel == RG_SWTRIG);
      pd_wr    = wr_en && (wr_sel == RG_PENDING);
      hw_hit   = enable_q & ((rise & rise_q) | (fall & fall_q));
      sw_val   = wr_data & CFG;
      sw_hit   = sw_wr ? (sw_val & ~swtrig_q & enable_q & ~pend_q) : '0;
      clr      = pd_wr ? (pend_q & wr_data & CFG) : '0;
      pend_d   = (pend_q & ~clr) | hw_hit | sw_hit;
      swtrig_d = sw_wr ? sw_val : (swtrig_q & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= FIX;
         event_q  <= '0;
         rise_q   <= '0;
         fall_q   <= '0;
         swtrig_q <= '0;
         pend_q   <= '0;
         pulse    <= '0;
      end else begin
         if (wr_en && wr_sel == RG_ENABLE) enable_q <= wr_data;
         if (wr_en && wr_sel == RG_EVENT)  event_q  <= wr_data;
         if (wr_en && wr_sel == RG_RISE)   rise_q   <= wr_data & CFG;
         if (wr_en && wr_sel == RG_FALL)   fall_q   <= wr_data & CFG;
         swtrig_q <= swtrig_d;
         pend_q   <= pend_d;
         pulse    <= hw_hit | sw_hit;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_sel)
         RG_ENABLE:  rd_data[W-1:0] = enable_q;
         RG_EVENT:   rd_data[W-1:0] = event_q;
         RG_RISE:    rd_data[W-1:0] = rise_q;
         RG_FALL:    rd_data[W-1:0] = fall_q;
         RG_SWTRIG:  rd_data[W-1:0] = swtrig_q;
         RG_PENDING: rd_data[W-1:0] = pend_q;
         default:    rd_data = '0;
      endcase
   end

   assign irq_req = |(pend_q & enable_q);
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
   import xint_pkg::*;
#(
   parameter int unsigned LINES_A     = 32,
   parameter int unsigned LINES_B     = 8,
   parameter logic [31:0] FIXED_A     = 32'hFF82_0000,
   parameter logic [31:0] FIXED_B     = 32'h0000_0087,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 10,
   localparam int unsigned NUM_LINES  = LINES_A + LINES_B
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata,
   output logic [NUM_LINES-1:0] line_pulse,
   output logic                 irq_any
);
   if (LINES_A < 1 || LINES_A > WORD_W) begin : g_bad_a
      $error("xint_ctrl: LINES_A must be 1..32");
   end
   if (LINES_B < 1 || LINES_B > WORD_W) begin : g_bad_b
      $error("xint_ctrl: LINES_B must be 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xint_ctrl: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("xint_ctrl: ADDR_W must be at least 7");
   end

   logic [NUM_LINES-1:0] rise, fall;
   logic                 dec_hit, dec_bank;
   reg_sel_e             dec_sel;
   logic [WORD_W-1:0]    bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;

   xint_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n(rst_n), .din(line_in), .rise(rise), .fall(fall)
   );

   xint_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(addr), .hit(dec_hit), .bank(dec_bank), .sel(dec_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned W   = (b == 0) ? LINES_A : LINES_B;
      localparam int unsigned LO  = (b == 0) ? 0 : LINES_A;
      localparam logic [31:0] FIX = (b == 0) ? FIXED_A : FIXED_B;
      logic bank_wr;

      assign bank_wr = wr_en && dec_hit && (dec_bank == b[0]);

      xint_bank #(.W(W), .FIXED(FIX)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .rise   (rise[LO +: W]),
         .fall   (fall[LO +: W]),
         .wr_en  (bank_wr),
         .wr_sel (dec_sel),
         .wr_data(wdata[W-1:0]),
         .rd_sel (dec_sel),
         .rd_data(bank_rd[b]),
         .pulse  (line_pulse[LO +: W]),
         .irq_req(bank_irq[b])
      );
   end

   assign rdata   = dec_hit ? bank_rd[dec_bank] : '0;
   assign irq_any = |bank_irq;
endmodule

// File: rtl/xint_chk.sv
module xint_chk #(
   parameter int unsigned N   = 40,
   parameter int unsigned LAT = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [N-1:0] line_in,
   input logic [N-1:0] line_pulse,
   input logic         irq_any
);
   logic [3:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
   end

   // R1: outputs are quiet on the first edge out of reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (line_pulse == '0 && !irq_any));

   // R9: any pulse implies an enabled pending flag
   p_pulse_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pulse != '0) |-> irq_any);

   // R7/R9: the combined output only drops after a bus write
   p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_any) |-> $past(wr_en));

   // R5/R6: a pulse comes from a bus write or a line change LAT edges earlier
   for (genvar i = 0; i < N; i++) begin : g_line
      p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst > 4'(LAT + 1) && line_pulse[i]) |->
            ($past(wr_en) || ($past(line_in[i], LAT) != $past(line_in[i], LAT + 1))));
   end
endmodule

bind xint_ctrl xint_chk #(.N(NUM_LINES), .LAT(SYNC_STAGES + 1)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .line_in   (line_in),
   .line_pulse(line_pulse),
   .irq_any   (irq_any)
);

// File: tb/sim_xint_ctrl.sv
`timescale 1ns/1ps
module sim_xint_ctrl;
   localparam logic [31:0] FIX_A = 32'hFF82_0000;
   localparam logic [7:0]  FIX_B = 8'h87;
   localparam logic [31:0] CFG_A = ~FIX_A;
   localparam logic [31:0] CFG_B = {24'h0, ~FIX_B};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] lines = '0;
   logic        wr_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [39:0] line_pulse;
   logic        irq_any;
   int          checks = 0;
   int          errors = 0;

   xint_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .line_in(lines), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .line_pulse(line_pulse), .irq_any(irq_any)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic move_line(input int i, input logic v);
      lines[i] = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic is_cfg(input int i);
      return (i < 32) ? CFG_A[i] : CFG_B[i-32];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v, va, vb;
      logic [39:0] exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 line_pulse", {24'h0, line_pulse}, 64'h0);
      check("R1 irq_any", {63'h0, irq_any}, 64'h0);
      for (int r = 0; r < 6; r++) begin
         rd(10'(r*4), v);
         check("R1 bank A reg", {32'h0, v}, (r == 0) ? {32'h0, FIX_A} : 64'h0);
         rd(10'(32 + r*4), v);
         check("R1 bank B reg", {32'h0, v}, (r == 0) ? {56'h0, FIX_B} : 64'h0);
      end

      // R2 / R3 register masking
      wr(10'h00, 32'hFFFF_FFFF); rd(10'h00, v); check("R3 enable A", {32'h0, v}, {32'h0, 32'hFFFF_FFFF});
      wr(10'h20, 32'hFFFF_FFFF); rd(10'h20, v); check("R2 enable B", {32'h0, v}, 64'hFF);
      wr(10'h04, 32'hFFFF_FFFF); rd(10'h04, v); check("R3 event A", {32'h0, v}, {32'h0, 32'hFFFF_FFFF});
      wr(10'h24, 32'hFFFF_FFFF); rd(10'h24, v); check("R2 event B", {32'h0, v}, 64'hFF);
      wr(10'h0C, 32'hFFFF_FFFF); rd(10'h0C, v); check("R3 fall A", {32'h0, v}, {32'h0, CFG_A});
      wr(10'h2C, 32'hFFFF_FFFF); rd(10'h2C, v); check("R3 fall B", {32'h0, v}, {32'h0, CFG_B});

      // R5 per-line sweep, rising mode then falling mode
      for (int mode = 0; mode < 2; mode++) begin
         wr(10'h08, (mode == 0) ? 32'hFFFF_FFFF : 32'h0);
         wr(10'h28, (mode == 0) ? 32'hFFFF_FFFF : 32'h0);
         wr(10'h0C, (mode == 1) ? 32'hFFFF_FFFF : 32'h0);
         wr(10'h2C, (mode == 1) ? 32'hFFFF_FFFF : 32'h0);
         for (int i = 0; i < 40; i++) begin
            exp = is_cfg(i) ? (40'h1 << i) : 40'h0;
            move_line(i, 1'b1);
            check("R5 rise pulse", {24'h0, line_pulse}, (mode == 0) ? {24'h0, exp} : 64'h0);
            @(negedge clk);
            check("R5 pulse width", {24'h0, line_pulse}, 64'h0);
            move_line(i, 1'b0);
            check("R5 fall pulse", {24'h0, line_pulse}, (mode == 1) ? {24'h0, exp} : 64'h0);
            rd(10'h14, va); rd(10'h34, vb);
            check("R5 pending", {24'h0, vb[7:0], va}, {24'h0, exp});
            wr(10'h14, 32'hFFFF_FFFF); wr(10'h34, 32'hFFFF_FFFF);
            rd(10'h14, va); rd(10'h34, vb);
            check("R7 cleared", {24'h0, vb[7:0], va}, 64'h0);
         end
      end
      wr(10'h08, 32'hFFFF_FFFF); wr(10'h0C, 32'h0);

      // R4 masked line
      wr(10'h00, 32'hFFFF_FFF7);
      move_line(3, 1'b1);
      check("R4 no pulse", {24'h0, line_pulse}, 64'h0);
      rd(10'h14, v); check("R4 no pending", {32'h0, v}, 64'h0);
      move_line(3, 1'b0);
      wr(10'h00, 32'hFFFF_FFFF);

      // R6 software trigger
      wr(10'h10, 32'h10);
      check("R6 fire", {24'h0, line_pulse}, 64'h10);
      rd(10'h14, v); check("R6 pending", {32'h0, v}, 64'h10);
      rd(10'h10, v); check("R6 stored", {32'h0, v}, 64'h10);
      wr(10'h10, 32'h10);
      check("R6 no refire", {24'h0, line_pulse}, 64'h0);
      wr(10'h14, 32'h0);
      rd(10'h14, v); check("R7 zero write", {32'h0, v}, 64'h10);
      wr(10'h14, 32'h10);
      rd(10'h14, v); check("R7 clear pending", {32'h0, v}, 64'h0);
      rd(10'h10, v); check("R7 clear swtrig", {32'h0, v}, 64'h0);
      wr(10'h00, 32'hFFFF_FFEF);
      wr(10'h10, 32'h10);
      check("R6 masked no fire", {24'h0, line_pulse}, 64'h0);
      rd(10'h10, v); check("R6 masked stored", {32'h0, v}, 64'h10);
      wr(10'h00, 32'hFFFF_FFFF);
      wr(10'h10, 32'h10);
      check("R6 stale bit no fire", {24'h0, line_pulse}, 64'h0);
      wr(10'h10, 32'h0);
      wr(10'h10, 32'h10);
      check("R6 new edge fires", {24'h0, line_pulse}, 64'h10);
      wr(10'h14, 32'h10);
      wr(10'h10, 32'h0002_0000);
      check("R3 fixed no fire", {24'h0, line_pulse}, 64'h0);
      rd(10'h10, v); check("R3 fixed swtrig", {32'h0, v}, 64'h0);
      move_line(5, 1'b1);
      wr(10'h10, 32'h20);
      check("R6 pending no fire", {24'h0, line_pulse}, 64'h0);
      rd(10'h10, v); check("R6 pending stored", {32'h0, v}, 64'h20);
      wr(10'h14, 32'h20);
      rd(10'h10, v); check("R7 swtrig follows", {32'h0, v}, 64'h0);
      move_line(5, 1'b0);
      wr(10'h30, 32'hFFFF_FFFF);
      check("R6 bank B fire", {24'h0, line_pulse}, {24'h0, CFG_B[7:0], 32'h0});
      rd(10'h34, v); check("R6 bank B pending", {32'h0, v}, {32'h0, CFG_B});
      wr(10'h34, 32'hFFFF_FFFF);
      rd(10'h30, v); check("R7 bank B swtrig", {32'h0, v}, 64'h0);

      // R9 combined output
      check("R9 idle", {63'h0, irq_any}, 64'h0);
      wr(10'h10, 32'h10);
      check("R9 set", {63'h0, irq_any}, 64'h1);
      wr(10'h00, 32'hFFFF_FFEF);
      check("R9 masked", {63'h0, irq_any}, 64'h0);
      rd(10'h14, v); check("R9 pending kept", {32'h0, v}, 64'h10);
      wr(10'h00, 32'hFFFF_FFFF);
      check("R9 unmasked", {63'h0, irq_any}, 64'h1);
      wr(10'h14, 32'h10);
      check("R9 cleared", {63'h0, irq_any}, 64'h0);

      // R10 set beats clear in the same cycle
      move_line(6, 1'b1);
      move_line(6, 1'b0);
      lines[6] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr_en = 1'b1; addr = 10'h14; wdata = 32'h40;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      check("R10 pulse", {24'h0, line_pulse}, 64'h40);
      rd(10'h14, v); check("R10 pending kept", {32'h0, v}, 64'h40);
      wr(10'h14, 32'h40);
      move_line(6, 1'b0);

      // R8 undefined and unaligned access
      wr(10'h18, 32'hFFFF_FFFF);
      rd(10'h18, v); check("R8 hole read", {32'h0, v}, 64'h0);
      rd(10'h3C, v); check("R8 hole B read", {32'h0, v}, 64'h0);
      rd(10'h40, v); check("R8 outside read", {32'h0, v}, 64'h0);
      wr(10'h01, 32'h0);
      rd(10'h00, v); check("R8 unaligned write", {32'h0, v}, {32'h0, 32'hFFFF_FFFF});
      rd(10'h02, v); check("R8 unaligned read", {32'h0, v}, 64'h0);
      wr(10'h52, 32'h10);
      check("R8 no fire", {24'h0, line_pulse}, 64'h0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule